// File: doc/BRIEF.md
# Boot-Time Register Initialization Write Screener

During early boot a header can carry a table of up to 256 address/data pairs that set up clocks, DMA pointers and delay taps before any later software runs. This block steps through that table one entry at a time and turns each entry into a 32-bit register write on a simple request/acknowledge interface. Before each write it checks the address against a fixed list of permitted windows. Some windows are a single word, and some sit between forbidden stretches of the same peripheral. The first address that lands in no permitted window, or that is not word aligned, stops the walk. No further write is issued, a sticky lockdown output rises and a fixed error code appears.

A start pulse launches a walk with a given entry count. The block reads the table through an index output and a same-cycle address/data input. When later boot code takes over, it raises the handoff input. From then on every entry is written as it stands, with no screening. Lockdown clears only on reset.

Top module: `reginit_screener`

## Requirements
- R1: After reset, wr_req, done and lockdown are 0, err_code is 0 and tbl_idx is 0.
- R2: Entries are written strictly in index order, one write per entry, carrying that entry's address and data. wr_req stays high with stable wr_addr and wr_data until a cycle with wr_ack high, and only then does the next entry begin.
- R3: An address is permitted when it lies inside one of the built-in windows, with both bounds inclusive. The windows include single words such as 0xF1010000, 0xF1330068 and 0xF1040000. Narrow stretches such as 0xF1260108..0xF126014C and 0xF1260154..0xF12601FC sit beside the forbidden word 0xF1260150.
- R4: While screening, an entry whose address is in no permitted window is never written, and no later entry is written either. lockdown rises and err_code reads 0x400. err_code reads 0 while lockdown is low.
- R5: While screening, an address with bits [1:0] not equal to 00 counts as a violation, even when it falls inside a window.
- R6: A start with entry_count 0 writes nothing and pulses done. A start with entry_count above 256 writes nothing and sets lockdown.
- R7: done is a single-cycle pulse after the last entry's write is acknowledged. It never pulses on a walk that ends in a violation.
- R8: lockdown and err_code hold until reset. While lockdown is set, start is ignored: no write is issued and done stays low.
- R9: When handoff is high in the cycle an entry is screened, that entry is written as it stands, including forbidden or misaligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk of the table (pulse) |
| entry_count | input | 10 | Number of table entries to process |
| handoff | input | 1 | High: skip screening |
| tbl_idx | output | 8 | Index of the table entry being read |
| tbl_addr | input | 32 | Address field of entry tbl_idx |
| tbl_data | input | 32 | Data field of entry tbl_idx |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle pulse when the walk finishes cleanly |
| lockdown | output | 1 | Sticky violation lock |
| err_code | output | 16 | 0x400 while locked, else 0 |

## Verification
Two events can meet in one cycle: handoff rising, and the screening of the next entry, which is forbidden. The bench raises handoff in the same cycle it acknowledges a chosen write. The next entry is then screened with handoff already high. The bench expects every entry after that write to pass, including a forbidden one, with no lockdown. A control walk of the same table without handoff must stop at that entry.

// File: rtl/rinit_pkg.sv
package rinit_pkg;

  localparam int ADDR_W  = 32;
  localparam int NUM_WIN = 18;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_WRITE = 2'd2
  } seq_state_t;

  // Lower bound of permitted window i (inclusive).
  function automatic logic [ADDR_W-1:0] win_lo(input int i);
    case (i)
      0:  return 32'hF133_0068;
      1:  return 32'hF126_0108;
      2:  return 32'hF126_0154;
      3:  return 32'hF101_0000;
      4:  return 32'hF101_0100;
      5:  return 32'hF103_0200;
      6:  return 32'hF104_0000;
      7:  return 32'hF104_0058;
      8:  return 32'hF104_0100;
      9:  return 32'hF105_0000;
      10: return 32'hF105_0058;
      11: return 32'hF105_0100;
      12: return 32'hF100_0000;
      13: return 32'hF102_0000;
      14: return 32'hF106_0000;
      15: return 32'hF110_0000;
      16: return 32'hF122_0000;
      17: return 32'hF127_0000;
      default: return '1;
    endcase
  endfunction

  // Upper bound of permitted window i (inclusive).
  function automatic logic [ADDR_W-1:0] win_hi(input int i);
    case (i)
      0:  return 32'hF133_0068;
      1:  return 32'hF126_014C;
      2:  return 32'hF126_01FC;
      3:  return 32'hF101_0000;
      4:  return 32'hF101_1FF8;
      5:  return 32'hF103_0828;
      6:  return 32'hF104_0000;
      7:  return 32'hF104_005C;
      8:  return 32'hF104_F0FC;
      9:  return 32'hF105_0000;
      10: return 32'hF105_005C;
      11: return 32'hF105_F0FC;
      12: return 32'hF100_0030;
      13: return 32'hF102_0324;
      14: return 32'hF106_0828;
      15: return 32'hF110_0FF8;
      16: return 32'hF122_030C;
      17: return 32'hF127_1F94;
      default: return '0;
    endcase
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic word_aligned(input logic [ADDR_W-1:0] a);
    return a[1:0] == 2'b00;
  endfunction

endpackage

// File: rtl/rinit_window_match.sv
module rinit_window_match #(
  parameter int ADDR_W  = rinit_pkg::ADDR_W,
  parameter int NUM_WIN = rinit_pkg::NUM_WIN
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] hit,
  output logic               aligned,
  output logic               addr_ok
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(rinit_pkg::win_lo(g));
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(rinit_pkg::win_hi(g));
    assign hit[g] = rinit_pkg::in_window(addr, LO, HI);
  end

  assign aligned = rinit_pkg::word_aligned(addr);
  assign addr_ok = aligned && (|hit);

endmodule

// File: rtl/rinit_sequencer.sv
module rinit_sequencer #(
  parameter int MAX_ENTRIES = 256,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 8,
  parameter int CNT_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  entry_count,
  input  logic              handoff,
  input  logic              locked,
  input  logic              addr_ok,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              viol,
  output logic              wr_checked
);
  import rinit_pkg::*;

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ENTRIES);

  seq_state_t       st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_q;
  logic             start_ok;
  logic             count_bad;
  logic             screen_bad;
  logic             last_entry;

  assign start_ok   = (st == S_IDLE) && start && !locked;
  assign count_bad  = start_ok && (entry_count > MAX_CNT);
  assign screen_bad = (st == S_CHECK) && !handoff && !addr_ok;
  assign viol       = count_bad || screen_bad;
  assign last_entry = (CNT_W'(idx) + CNT_W'(1)) == cnt_q;
  assign tbl_idx    = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      cnt_q      <= '0;
      wr_req     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_checked <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_ok && !count_bad) begin
            if (entry_count == '0) begin
              done <= 1'b1;
            end else begin
              cnt_q <= entry_count;
              idx   <= '0;
              st    <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (screen_bad) begin
            st <= S_IDLE;
          end else begin
            wr_addr    <= tbl_addr;
            wr_data    <= tbl_data;
            wr_checked <= !handoff;
            wr_req     <= 1'b1;
            st         <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_ack) begin
            wr_req <= 1'b0;
            if (last_entry) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              idx <= idx + IDX_W'(1);
              st  <= S_CHECK;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rinit_lock.sv
module rinit_lock #(
  parameter int              ERR_W    = 16,
  parameter logic [ERR_W-1:0] ERR_CODE = 16'h0400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             viol,
  output logic             lockdown,
  output logic [ERR_W-1:0] err_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockdown <= 1'b0;
      err_code <= '0;
    end else if (viol) begin
      lockdown <= 1'b1;
      err_code <= ERR_CODE;
    end
  end

endmodule

// File: rtl/reginit_screener.sv
module reginit_screener #(
  parameter int               MAX_ENTRIES = 256,
  parameter int               DATA_W      = 32,
  parameter int               ERR_W       = 16,
  parameter logic [ERR_W-1:0] ERR_CODE    = 16'h0400,
  localparam int              ADDR_W      = rinit_pkg::ADDR_W,
  localparam int              IDX_W       = $clog2(MAX_ENTRIES),
  localparam int              CNT_W       = $clog2(MAX_ENTRIES) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  entry_count,
  input  logic              handoff,
  output logic [IDX_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              lockdown,
  output logic [ERR_W-1:0]  err_code
);

  // Internal events brought out for the checker.
  logic [rinit_pkg::NUM_WIN-1:0] win_hit;
  logic                          win_aligned;
  logic                          win_ok;
  logic                          seq_viol;
  logic                          seq_wr_checked;

  rinit_window_match #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(rinit_pkg::NUM_WIN)
  ) u_match (
    .addr   (tbl_addr),
    .hit    (win_hit),
    .aligned(win_aligned),
    .addr_ok(win_ok)
  );

  rinit_sequencer #(
    .MAX_ENTRIES(MAX_ENTRIES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .entry_count(entry_count),
    .handoff    (handoff),
    .locked     (lockdown),
    .addr_ok    (win_ok),
    .tbl_addr   (tbl_addr),
    .tbl_data   (tbl_data),
    .tbl_idx    (tbl_idx),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_ack     (wr_ack),
    .done       (done),
    .viol       (seq_viol),
    .wr_checked (seq_wr_checked)
  );

  rinit_lock #(
    .ERR_W   (ERR_W),
    .ERR_CODE(ERR_CODE)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .viol    (seq_viol),
    .lockdown(lockdown),
    .err_code(err_code)
  );

endmodule

// File: rtl/rinit_checker.sv
module rinit_checker #(
  parameter int               NUM_WIN  = 18,
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter int               ERR_W    = 16,
  parameter logic [ERR_W-1:0] ERR_CODE = 16'h0400
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_req,
  input logic               wr_ack,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               done,
  input logic               lockdown,
  input logic [ERR_W-1:0]   err_code,
  input logic               viol,
  input logic               wr_checked,
  input logic [NUM_WIN-1:0] hit
);

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  a_r3_windows_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  a_r4_violation_locks: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> lockdown && (err_code == ERR_CODE));

  a_r4_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |-> !wr_req && !done);

  a_r5_checked_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_checked |-> wr_addr[1:0] == 2'b00);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lockdown && !wr_req);

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> lockdown && $stable(err_code));

endmodule

bind reginit_screener rinit_checker #(
  .NUM_WIN (rinit_pkg::NUM_WIN),
  .ADDR_W  (rinit_pkg::ADDR_W),
  .DATA_W  (DATA_W),
  .ERR_W   (ERR_W),
  .ERR_CODE(ERR_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_req    (wr_req),
  .wr_ack    (wr_ack),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .done      (done),
  .lockdown  (lockdown),
  .err_code  (err_code),
  .viol      (seq_viol),
  .wr_checked(seq_wr_checked),
  .hit       (win_hit)
);

// File: tb/test_reginit_screener.sv
`timescale 1ns/1ps
module test_reginit_screener;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  entry_count = '0;
  logic        handoff = 1'b0;
  logic [7:0]  tbl_idx;
  logic [31:0] tbl_addr, tbl_data;
  logic        wr_req;
  logic [31:0] wr_addr, wr_data;
  logic        wr_ack = 1'b0;
  logic        done, lockdown;
  logic [15:0] err_code;

  logic [31:0] t_addr [256];
  logic [31:0] t_data [256];
  logic [31:0] log_addr [300];
  logic [31:0] log_data [300];
  int          log_n = 0;
  int          ho_idx = -1;
  int          n_checks = 0, n_bad = 0;
  bit          finished = 0;

  assign tbl_addr = t_addr[tbl_idx];
  assign tbl_data = t_data[tbl_idx];

  always #10 clk = ~clk;

  reginit_screener i_reginit_screener (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_count(entry_count),
    .handoff(handoff), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .done(done),
    .lockdown(lockdown), .err_code(err_code));

  // Bench model of the permitted address space, written per peripheral.
  function automatic bit bench_ok(input logic [31:0] a);
    logic [15:0] o;
    o = a[15:0];
    if (a[1:0] != 2'b00) return 0;
    case (a[31:16])
      16'hF100: return o <= 16'h0030;
      16'hF101: return (o == 16'h0000) || (o >= 16'h0100 && o <= 16'h1FF8);
      16'hF102: return o <= 16'h0324;
      16'hF103: return o >= 16'h0200 && o <= 16'h0828;
      16'hF104, 16'hF105:
        return (o == 16'h0000) || (o >= 16'h0058 && o <= 16'h005C) ||
               (o >= 16'h0100 && o <= 16'hF0FC);
      16'hF106: return o <= 16'h0828;
      16'hF110: return o <= 16'h0FF8;
      16'hF122: return o <= 16'h030C;
      16'hF126: return (o >= 16'h0108 && o <= 16'h014C) ||
                       (o >= 16'h0154 && o <= 16'h01FC);
      16'hF127: return o <= 16'h1F94;
      16'hF133: return o == 16'h0068;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [31:0] rand_addr();
    logic [15:0] pfx [12] = '{16'hF100, 16'hF101, 16'hF102, 16'hF103,
                              16'hF104, 16'hF105, 16'hF106, 16'hF110,
                              16'hF122, 16'hF126, 16'hF127, 16'hF133};
    logic [15:0] off;
    off = 16'($urandom_range(0, 16'h1FFF)) & 16'hFFFC;
    return {pfx[$urandom_range(0, 11)], off};
  endfunction

  function automatic logic [31:0] rand_good();
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a;
      a = rand_addr();
      if (bench_ok(a)) return a;
    end
    return 32'hF102_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Write responder: random acknowledge latency, logs each accepted write.
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk);
      if (wr_ack) begin
        wr_ack = 1'b0;
      end else if (wr_req) begin
        if (wait_n == 0) begin
          if (log_n < 300) begin
            log_addr[log_n] = wr_addr;
            log_data[log_n] = wr_data;
          end
          if (log_n == ho_idx) handoff = 1'b1;
          log_n++;
          wr_ack = 1'b1;
          wait_n = $urandom_range(0, 3);
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; handoff = 1'b0; ho_idx = -1;
    entry_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Runs one walk and compares against the bench model.
  task automatic run_and_check(input int n, input string req);
    int exp_n = 0;
    bit exp_lock = lockdown;
    bit exp_done = 0;
    int done_seen = 0;
    bit ho = handoff;
    if (!exp_lock) begin
      if (n > 256) exp_lock = 1;
      else begin
        exp_done = 1;
        for (int i = 0; i < n; i++) begin
          bit screened;
          screened = !(ho || (ho_idx >= 0 && i > ho_idx));
          if (screened && !bench_ok(t_addr[i])) begin
            exp_lock = 1; exp_done = 0; break;
          end
          exp_n++;
        end
      end
    end
    log_n = 0;
    start = 1'b1;
    entry_count = 10'(n);
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (done) done_seen++;
      if (done || (lockdown && k > 20)) break;
      if (lockdown && !exp_lock) break;
    end
    @(negedge clk);
    if (done) done_seen++;
    chk(log_n == exp_n, req, "write count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_addr[i] == t_addr[i] && log_data[i] == t_data[i], req,
          $sformatf("write %0d addr", i), log_addr[i], t_addr[i]);
    end
    chk(lockdown == exp_lock, "R4", "lockdown", lockdown, exp_lock);
    chk(err_code == (exp_lock ? 16'h0400 : 16'h0000), "R4", "err_code",
        err_code, exp_lock ? 16'h0400 : 16'h0000);
    chk(done_seen == (exp_done ? 1 : 0), "R7", "done pulses", done_seen,
        exp_done ? 1 : 0);
  endtask

  task automatic fill_good(input int n);
    for (int i = 0; i < n; i++) begin
      t_addr[i] = rand_good();
      t_data[i] = $urandom();
    end
  endtask

  initial begin
    logic [31:0] edge_ok [16] = '{32'hF126_014C, 32'hF126_0154, 32'hF126_0108,
      32'hF126_01FC, 32'hF133_0068, 32'hF101_0000, 32'hF101_1FF8,
      32'hF103_0200, 32'hF103_0828, 32'hF104_0058, 32'hF104_005C,
      32'hF105_F0FC, 32'hF122_0000, 32'hF127_1F94, 32'hF110_0FF8,
      32'hF102_0324};
    logic [31:0] edge_bad [10] = '{32'hF126_0150, 32'hF133_006C,
      32'hF101_0004, 32'hF103_01FC, 32'hF104_0054, 32'hF104_0060,
      32'hF126_0104, 32'hF126_0200, 32'hF102_0328, 32'h0000_0000};
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin t_addr[i] = '0; t_data[i] = '0; end
    do_reset();

    // R1: reset state
    chk(!wr_req && !done && !lockdown, "R1", "idle outputs",
        {wr_req, done, lockdown}, 0);
    chk(err_code == 0 && tbl_idx == 0, "R1", "err_code/idx", err_code, 0);

    // R6: empty table
    run_and_check(0, "R6");

    // R3: inclusive window edges and single-word windows
    foreach (edge_ok[i]) begin t_addr[i] = edge_ok[i]; t_data[i] = $urandom(); end
    run_and_check(16, "R3");

    // R2: full 256-entry random permitted table
    fill_good(256);
    run_and_check(256, "R2");

    // R4: each forbidden address stops the walk at its position
    foreach (edge_bad[j]) begin
      do_reset();
      fill_good(6);
      t_addr[3] = edge_bad[j];
      run_and_check(6, "R4");
    end

    // R5: misaligned address inside a window
    do_reset();
    fill_good(4);
    t_addr[1] = 32'hF102_0002;
    run_and_check(4, "R5");

    // R8: start ignored while locked, then reset clears
    fill_good(5);
    run_and_check(5, "R8");
    chk(lockdown == 1'b1, "R8", "still locked", lockdown, 1);
    do_reset();
    chk(!lockdown && err_code == 0, "R1", "lock cleared by reset", lockdown, 0);

    // R6: count above the table limit
    run_and_check(257, "R6");

    // R9: handoff high from the start lets forbidden entries through
    do_reset();
    fill_good(6);
    t_addr[1] = 32'hF126_0150;
    t_addr[4] = 32'hF100_0031;
    handoff = 1'b1;
    run_and_check(6, "R9");

    // R9: handoff rises with the ack of write 2; entry 3 is forbidden
    do_reset();
    fill_good(6);
    t_addr[3] = 32'hF103_0000;
    ho_idx = 2;
    run_and_check(6, "R9");

    // R4/R2: random tables with an occasional forbidden entry
    for (int r = 0; r < 12; r++) begin
      int n;
      do_reset();
      n = $urandom_range(1, 40);
      for (int i = 0; i < n; i++) begin
        t_addr[i] = ($urandom_range(0, 9) == 0) ? rand_addr() : rand_good();
        t_data[i] = $urandom();
      end
      run_and_check(n, "R2");
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule